// File: doc/BRIEF.md
# Boot Image Loader from Serial Flash

This block runs once after power-on. It keeps the processor in reset, reads a fixed-size program image out of an external serial (SPI) flash and writes it into on-chip RAM. Once the copy is complete, the RAM can serve as program memory in place of internal flash. The block then releases the processor reset and raises a power-down request, so that the clock and supply of the flash interface can be switched off.

The sequencer moves through five named states. `ST_IDLE` is entered from reset and always goes to `ST_CMD` on the next cycle. `ST_CMD` shifts out the read opcode and goes to `ST_ADDR` when its byte completes. `ST_ADDR` shifts out three zero address bytes and goes to `ST_DATA` after the third one. `ST_DATA` receives `IMAGE_BYTES` bytes and goes to `ST_DONE` after the last one. `ST_DONE` is terminal: the chip select is high, the serial clock is low, the processor runs and the flash path is powered down.

The serial link runs in SPI mode 0 at half the system clock. Received bytes are packed into 32-bit RAM words in little-endian order, and the RAM sees one write strobe for every four bytes.

Top module: `boot_image_loader`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` is 1, `spi_sck` is 0, `cpu_rst_n` is 0, `flash_pd` is 0 and `ram_we` is 0.
- R2: The first 8 bits shifted on `spi_mosi` after chip select falls form the read opcode 0x03, sent MSB first.
- R3: The read opcode is followed by 24 address bits, all zero, so reading starts at flash byte 0.
- R4: `spi_sck` idles low and each bit takes two system cycles (one low, one high). `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is taken as it stands during the high phase that follows a rising edge.
- R5: Exactly `IMAGE_BYTES` data bytes are read. Data byte k lands in bits [8*(k%4)+7 : 8*(k%4)] of RAM word k/4.
- R6: Each group of four bytes gives one single-cycle `ram_we` pulse. Word addresses start at 0 and rise by one per pulse. Two pulses are never adjacent.
- R7: After the last data byte, `spi_cs_n` goes high and stays high, and `spi_sck` stays low.
- R8: `cpu_rst_n` stays 0 until the cycle after the final RAM write. It rises after system edge 66 + 16*`IMAGE_BYTES`, counting the first edge that sees `rst_n` high as edge 1. The write of word j follows edge 129 + 64*j.
- R9: `flash_pd` rises together with `cpu_rst_n` and stays high.
- R10: Once the processor is released, no further flash transaction starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| spi_sck | output | 1 | Serial clock to flash (mode 0, clk/2) |
| spi_cs_n | output | 1 | Active-low flash chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | $clog2(IMAGE_BYTES/4) | RAM word address |
| ram_wdata | output | 32 | RAM write data, little-endian packed |
| cpu_rst_n | output | 1 | Active-low processor reset, released after copy |
| flash_pd | output | 1 | Request to gate flash interface clock and power |

## Verification
The bench builds the loader with `IMAGE_BYTES` = 64, so the whole copy of 16 words takes about a thousand cycles. At that size every word can be compared against a byte pattern the bench computes arithmetically, and the system edge of every write strobe can be checked against 129 + 64*j. The same build makes the release edge of the processor reset reachable for an exact check. A behavioural flash model captures the 32 header bits, which confirms the opcode and the zero start address.

// File: rtl/bootld_pkg.sv
package bootld_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_DONE
    } ld_state_t;

    localparam logic [7:0] RD_OPCODE  = 8'h03;
    localparam int         ADDR_BYTES = 3;
endpackage

// File: rtl/bootld_spi_phy.sv
// Mode-0 serial shifter at clk/2: rise on one cycle, sample and shift on the next.
module bootld_spi_phy (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       byte_tick,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_sh;
    logic [6:0] rx_sh;
    logic [2:0] bit_idx;
    logic       sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_idx <= '0;
            sck_q   <= 1'b0;
        end else if (load) begin
            tx_sh   <= tx_byte;
            bit_idx <= '0;
            sck_q   <= 1'b0;
        end else if (!run) begin
            sck_q <= 1'b0;
        end else if (!sck_q) begin
            sck_q <= 1'b1;
        end else begin
            sck_q   <= 1'b0;
            tx_sh   <= {tx_sh[6:0], 1'b0};
            rx_sh   <= {rx_sh[5:0], miso};
            bit_idx <= bit_idx + 3'd1;
        end
    end

    assign sck       = sck_q;
    assign mosi      = tx_sh[7];
    assign byte_tick = run && sck_q && (bit_idx == 3'd7);
    assign rx_byte   = {rx_sh, miso};
endmodule

// File: rtl/bootld_packer.sv
// Gathers bytes little-endian and emits one word write per four bytes.
module bootld_packer #(
    parameter int WORD_AW = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid,
    input  logic [7:0]         byte_in,
    output logic               ram_we,
    output logic [WORD_AW-1:0] ram_addr,
    output logic [31:0]        ram_wdata
);
    localparam logic [WORD_AW-1:0] ADDR_STEP = 1;

    logic [1:0]         lane;
    logic [23:0]        acc;
    logic [WORD_AW-1:0] waddr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane      <= '0;
            acc       <= '0;
            waddr     <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= 1'b0;
            if (byte_valid) begin
                lane <= lane + 2'd1;
                if (lane == 2'd3) begin
                    ram_we    <= 1'b1;
                    ram_wdata <= {byte_in, acc};
                    ram_addr  <= waddr;
                    waddr     <= waddr + ADDR_STEP;
                end else begin
                    for (int i = 0; i < 3; i++) begin
                        if (lane == 2'(i)) acc[8*i +: 8] <= byte_in;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bootld_seq.sv
// Copy sequencer: idle -> command -> address -> data -> done.
module bootld_seq
    import bootld_pkg::*;
#(
    parameter int IMAGE_BYTES = 65536,
    parameter int CNT_W       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_tick,
    output logic load,
    output logic run,
    output logic cs_n,
    output logic data_phase,
    output logic cpu_rst_n,
    output logic flash_pd
);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(IMAGE_BYTES - 1);

    ld_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = ST_CMD;
            ST_CMD:  if (byte_tick) state_nx = ST_ADDR;
            ST_ADDR: if (byte_tick && cnt == LAST_ADDR) state_nx = ST_DATA;
            ST_DATA: if (byte_tick && cnt == LAST_DATA) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_DONE;
            default: state_nx = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (byte_tick) cnt <= (state_nx != state) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        load       = (state == ST_IDLE);
        run        = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DATA);
        cs_n       = !run;
        data_phase = (state == ST_DATA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rst_n <= 1'b0;
            flash_pd  <= 1'b0;
        end else begin
            cpu_rst_n <= (state == ST_DONE);
            flash_pd  <= (state == ST_DONE);
        end
    end
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
    import bootld_pkg::*;
#(
    parameter int IMAGE_BYTES = 65536
) (
    input  logic                               clk,
    input  logic                               rst_n,
    output logic                               spi_sck,
    output logic                               spi_cs_n,
    output logic                               spi_mosi,
    input  logic                               spi_miso,
    output logic                               ram_we,
    output logic [$clog2(IMAGE_BYTES/4)-1:0]   ram_addr,
    output logic [31:0]                        ram_wdata,
    output logic                               cpu_rst_n,
    output logic                               flash_pd
);
    localparam int WORD_AW = $clog2(IMAGE_BYTES / 4);
    localparam int CNT_W   = $clog2(IMAGE_BYTES);

    logic       load, run, data_phase, byte_tick;
    logic [7:0] rx_byte;

    bootld_seq #(.IMAGE_BYTES(IMAGE_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_tick  (byte_tick),
        .load       (load),
        .run        (run),
        .cs_n       (spi_cs_n),
        .data_phase (data_phase),
        .cpu_rst_n  (cpu_rst_n),
        .flash_pd   (flash_pd)
    );

    bootld_spi_phy u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .run       (run),
        .tx_byte   (RD_OPCODE),
        .miso      (spi_miso),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .byte_tick (byte_tick),
        .rx_byte   (rx_byte)
    );

    bootld_packer #(.WORD_AW(WORD_AW)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_tick && data_phase),
        .byte_in    (rx_byte),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );
endmodule

// File: rtl/bootld_checker.sv
module bootld_checker (
    input logic clk,
    input logic rst_n,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi,
    input logic ram_we,
    input logic cpu_rst_n,
    input logic flash_pd
);
    a_r8_hold_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !cpu_rst_n);

    a_r6_we_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    a_r9_pd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flash_pd |=> flash_pd);

    a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    a_r10_no_new_select: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |=> spi_cs_n);
endmodule

bind boot_image_loader bootld_checker u_chk (.*);

// File: tb/boot_image_loader_tb.sv
module boot_image_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_BYTES    = 64;
    localparam int N_WORDS    = N_BYTES / 4;
    localparam int AW         = $clog2(N_WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck, cs_n, mosi, miso;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [31:0]   ram_wdata;
    logic          cpu_rst_n, flash_pd;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_image_loader #(.IMAGE_BYTES(N_BYTES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (sck),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .cpu_rst_n (cpu_rst_n),
        .flash_pd  (flash_pd)
    );

    function automatic logic [7:0] fbyte(input int k);
        return 8'((k * 73 + 29) ^ (k >> 2));
    endfunction

    // behavioural flash
    int          fl_bits = 0;
    logic [31:0] hdr = '0;
    int          n_select = 0;
    initial miso = 1'b0;

    always @(negedge cs_n) begin
        fl_bits  = 0;
        n_select = n_select + 1;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            if (fl_bits < 32) hdr = {hdr[30:0], mosi};
            fl_bits = fl_bits + 1;
        end
    end

    always @(negedge sck) begin
        if (!cs_n && fl_bits >= 32) begin
            logic [7:0] b;
            b    = fbyte((fl_bits - 32) / 8);
            miso = b[7 - ((fl_bits - 32) % 8)];
        end
    end

    // monitors
    int          edge_cnt = 0;
    int          rel_edge = 0;
    int          wr_cnt = 0;
    logic [31:0] got_data [N_WORDS];
    int          got_addr [N_WORDS];
    int          got_edge [N_WORDS];

    always @(posedge clk) if (rst_n) edge_cnt = edge_cnt + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_rst_n && rel_edge == 0) rel_edge = edge_cnt;
            if (ram_we) begin
                if (wr_cnt < N_WORDS) begin
                    got_data[wr_cnt] = ram_wdata;
                    got_addr[wr_cnt] = int'(ram_addr);
                    got_edge[wr_cnt] = edge_cnt;
                end
                wr_cnt = wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1,      "R1 cs_n in reset",      32'(cs_n), 32'h1);
        chk(sck == 1'b0,       "R1 sck in reset",       32'(sck), 32'h0);
        chk(cpu_rst_n == 1'b0, "R1 cpu_rst_n in reset", 32'(cpu_rst_n), 32'h0);
        chk(flash_pd == 1'b0,  "R1 flash_pd in reset",  32'(flash_pd), 32'h0);
        chk(ram_we == 1'b0,    "R1 ram_we in reset",    32'(ram_we), 32'h0);
        rst_n = 1'b1;

        while (!cpu_rst_n && edge_cnt < 5000) @(negedge clk);
        repeat (60) @(negedge clk);

        chk(hdr[31:24] == 8'h03, "R2 read opcode",      32'(hdr[31:24]), 32'h03);
        chk(hdr[23:0] == 24'h0,  "R3 zero start address", 32'(hdr[23:0]), 32'h0);
        chk(wr_cnt == N_WORDS,   "R6 write strobe count", 32'(wr_cnt), 32'(N_WORDS));
        for (int j = 0; j < N_WORDS && j < wr_cnt; j++) begin
            logic [31:0] expw;
            expw = {fbyte(4*j+3), fbyte(4*j+2), fbyte(4*j+1), fbyte(4*j)};
            chk(got_data[j] == expw,       "R5 word content",   got_data[j], expw);
            chk(got_addr[j] == j,          "R6 word address",   32'(got_addr[j]), 32'(j));
            chk(got_edge[j] == 129 + 64*j, "R4 R8 write timing", 32'(got_edge[j]), 32'(129 + 64*j));
        end
        chk(rel_edge == 66 + 16*N_BYTES, "R8 release edge", 32'(rel_edge), 32'(66 + 16*N_BYTES));
        chk(flash_pd == 1'b1,  "R9 power-down held",   32'(flash_pd), 32'h1);
        chk(cs_n == 1'b1,      "R7 chip deselected",   32'(cs_n), 32'h1);
        chk(sck == 1'b0,       "R7 sck idle low",      32'(sck), 32'h0);
        chk(n_select == 1,     "R10 single transaction", 32'(n_select), 32'h1);
        chk(cpu_rst_n == 1'b1, "R8 processor running", 32'(cpu_rst_n), 32'h1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog actual=timeout expected=release");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule